// File: doc/BRIEF.md
# Instruction Fetch Error Deferral Unit

This block sits between a small direct-mapped instruction cache and the execute stage. When the fetcher misses on a cacheable address, the unit asks the memory bus for the whole line and accepts eight 32-bit beats in order. Each beat may carry an error flag. That flag is kept as a tag beside the word it came with. It is not reported while the line is being filled, and it is not reported when the fetcher reads the word. A speculative fetch that never reaches execution therefore leaves no trace.

The execute stage presents the address of each instruction it is about to issue. If that word is cached and its tag marks it as bad, the unit kills the issue in the same cycle. At the next clock edge it pulses a machine-check request, saves the instruction address, sets a sticky status bit that marks the check as coming from instruction fetch, and invalidates the line. The error tags of a line are rewritten on every refill and cleared on invalidation. A clean refill or an eviction therefore discards a pending error.

Top module: `ifd_unit`

## Requirements
- R1: A fetch miss with `fetch_cacheable` high, while no fill is running, causes `mem_req` to be high for exactly one cycle, the cycle after the request. In that cycle `mem_line_addr` is the fetch address with its low 5 bits cleared. Eight beats on `mem_beat_valid` then fill words 0 to 7 in order. After the edge that takes the eighth beat, a fetch of word k hits and returns beat k.
- R2: A fetch miss with `fetch_cacheable` low starts no fill: `mem_req` stays low and `fetch_hit` stays low.
- R3: A beat with `mem_beat_err` high raises neither `mc_req` nor `issue_kill`, either during the fill or when the fetcher later reads that word. The fetch still hits and returns the beat data.
- R4: Issuing an error-free word of a line that also holds bad words gives `issue_kill` low and no `mc_req`.
- R5: Issuing a cached word whose tag is bad drives `issue_kill` high in the same cycle.
- R6: `mc_req` is high in exactly the cycle after a killed issue, for one cycle only.
- R7: `mc_save_addr` takes the killed issue address at that edge and holds it until the next machine check.
- R8: `mc_syndrome_ifetch` is set at that edge and stays set until reset.
- R9: The line holding the bad word is invalidated at that edge. Afterwards a fetch of any word of that line misses.
- R10: Refilling a line with error-free beats clears its error tags. Issuing the formerly bad word then gives no kill and no machine check.
- R11: If the line is evicted by a fill of another tag at the same index before its bad word is issued, issuing the old address gives no kill and no machine check.
- R12: After reset, `mem_req`, `mc_req`, `mc_syndrome_ifetch` and `mc_save_addr` are zero, and no fetch hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_req | input | 1 | Fetcher looks up `fetch_addr` |
| fetch_addr | input | 32 | Byte address of the fetched word |
| fetch_cacheable | input | 1 | Address may be allocated on a miss |
| fetch_hit | output | 1 | Word is present in the cache |
| fetch_data | output | 32 | Word returned on a hit |
| mem_req | output | 1 | One-cycle request for a line fill |
| mem_line_addr | output | 32 | Base address of the requested line |
| mem_beat_valid | input | 1 | A fill beat is on the bus |
| mem_beat_data | input | 32 | Beat data |
| mem_beat_err | input | 1 | Beat carries a bus error |
| issue_valid | input | 1 | Execute stage attempts to issue |
| issue_addr | input | 32 | Address of the instruction being issued |
| issue_kill | output | 1 | Suppress this issue (same cycle) |
| mc_req | output | 1 | Machine-check request pulse |
| mc_save_addr | output | 32 | Address of the suppressed instruction |
| mc_syndrome_ifetch | output | 1 | Sticky: machine check came from instruction fetch |

## Verification
The delicate coincidence is a machine check on one line in the same clock cycle as a fill beat that writes a different line. In that cycle the invalidation and the data-and-tag write land in the same storage. The bench provokes it by issuing the bad word of a resident line during the fourth beat of a fill to another index. It then checks four things: the kill in that cycle, the single request pulse with the saved address and status bit, a miss on the struck line, and correct data in the newly filled line.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_FILL = 1'b1
    } fill_st_e;
endpackage

// File: rtl/ifd_fill_ctrl.sv
module ifd_fill_ctrl
    import ifd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORDS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              beat_valid,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] line_addr,
    output logic              beat_we,
    output logic [$clog2(WORDS)-1:0] beat_word,
    output logic              done
);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int LB     = OFF_W + 2;
    localparam int BASE_W = ADDR_W - LB;

    typedef struct packed {
        fill_st_e          st;
        logic [OFF_W-1:0]  cnt;
        logic              req;
        logic [BASE_W-1:0] base;
    } fc_t;

    fc_t q, d;

    logic unused_low;
    assign unused_low = ^start_addr[LB-1:0];

    always_comb begin
        d       = q;
        d.req   = 1'b0;
        beat_we = (q.st == FS_FILL) && beat_valid;
        done    = beat_we && (q.cnt == OFF_W'(WORDS - 1));
        case (q.st)
            FS_IDLE: begin
                if (start) begin
                    d.st   = FS_FILL;
                    d.cnt  = '0;
                    d.req  = 1'b1;
                    d.base = start_addr[ADDR_W-1:LB];
                end
            end
            FS_FILL: begin
                if (beat_valid) begin
                    d.cnt = q.cnt + 1'b1;
                    if (done) d.st = FS_IDLE;
                end
            end
            default: d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: FS_IDLE, cnt: '0, req: 1'b0, base: '0};
        else        q <= d;
    end

    assign busy      = (q.st == FS_FILL);
    assign mem_req   = q.req;
    assign line_addr = {q.base, {LB{1'b0}}};
    assign beat_word = q.cnt;

    // R1: a fill request lasts one cycle only
    a_r1_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R1: a new fill is never launched over a running one
    a_r1_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/ifd_line_store.sv
module ifd_line_store #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              fill_begin,
    input  logic [ADDR_W-1:0] begin_addr,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              beat_we,
    input  logic [$clog2(WORDS)-1:0] beat_word,
    input  logic [DATA_W-1:0] beat_data,
    input  logic              beat_err,
    input  logic              fill_done,
    input  logic              inval_en,
    output logic              fetch_present,
    output logic [DATA_W-1:0] fetch_data,
    output logic              issue_present,
    output logic              issue_bad_tag
);
    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int IDX_L = 2 + OFF_W;
    localparam int TAG_L = IDX_L + IDX_W;
    localparam int TAG_W = ADDR_W - TAG_L;

    typedef struct packed {
        logic [LINES-1:0]                         valid;
        logic [LINES-1:0][TAG_W-1:0]              tag;
        logic [LINES-1:0][WORDS-1:0][DATA_W-1:0]  data;
        logic [LINES-1:0][WORDS-1:0]              err;
    } ls_t;

    ls_t q, d;

    logic [IDX_W-1:0] fe_idx, is_idx, bg_idx, fl_idx;
    logic [OFF_W-1:0] fe_off, is_off;
    logic [TAG_W-1:0] fe_tag, is_tag, fl_tag;

    assign fe_idx = fetch_addr[IDX_L +: IDX_W];
    assign fe_off = fetch_addr[2 +: OFF_W];
    assign fe_tag = fetch_addr[ADDR_W-1:TAG_L];
    assign is_idx = issue_addr[IDX_L +: IDX_W];
    assign is_off = issue_addr[2 +: OFF_W];
    assign is_tag = issue_addr[ADDR_W-1:TAG_L];
    assign bg_idx = begin_addr[IDX_L +: IDX_W];
    assign fl_idx = fill_addr[IDX_L +: IDX_W];
    assign fl_tag = fill_addr[ADDR_W-1:TAG_L];

    logic unused_bits;
    assign unused_bits = ^{fetch_addr[1:0], issue_addr[1:0],
                           begin_addr[ADDR_W-1:TAG_L], begin_addr[IDX_L-1:0],
                           fill_addr[IDX_L-1:0]};

    always_comb begin
        d = q;
        if (fill_begin) d.valid[bg_idx] = 1'b0;
        if (beat_we) begin
            d.data[fl_idx][beat_word] = beat_data;
            d.err[fl_idx][beat_word]  = beat_err;
        end
        if (fill_done) begin
            d.valid[fl_idx] = 1'b1;
            d.tag[fl_idx]   = fl_tag;
        end
        if (inval_en) begin
            d.valid[is_idx] = 1'b0;
            d.err[is_idx]   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fetch_present = q.valid[fe_idx] && (q.tag[fe_idx] == fe_tag);
    assign fetch_data    = q.data[fe_idx][fe_off];
    assign issue_present = q.valid[is_idx] && (q.tag[is_idx] == is_tag);
    assign issue_bad_tag = q.err[is_idx][is_off];

    // R9: a machine check removes the struck line
    a_r9_line_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        inval_en |=> !q.valid[$past(is_idx)]);
    // R1: the last beat makes the line resident
    a_r1_line_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> q.valid[$past(fl_idx)]);
endmodule

// File: rtl/ifd_mc_capture.sv
module ifd_mc_capture #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bad_issue,
    input  logic [ADDR_W-1:0] bad_addr,
    output logic              mc_req,
    output logic [ADDR_W-1:0] save_addr,
    output logic              syndrome
);
    typedef struct packed {
        logic              req;
        logic              syn;
        logic [ADDR_W-1:0] addr;
    } mc_t;

    mc_t q, d;

    always_comb begin
        d     = q;
        d.req = 1'b0;
        if (bad_issue) begin
            d.req  = 1'b1;
            d.syn  = 1'b1;
            d.addr = bad_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mc_req    = q.req;
    assign save_addr = q.addr;
    assign syndrome  = q.syn;

    // R8: the status bit never falls outside reset
    a_r8_syndrome_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        syndrome |=> syndrome);
    // R7: the saved address only moves with a request
    a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_req |-> $stable(save_addr));
endmodule

// File: rtl/ifd_unit.sv
module ifd_unit #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_cacheable,
    output logic              fetch_hit,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_line_addr,
    input  logic              mem_beat_valid,
    input  logic [DATA_W-1:0] mem_beat_data,
    input  logic              mem_beat_err,
    input  logic              issue_valid,
    input  logic [ADDR_W-1:0] issue_addr,
    output logic              issue_kill,
    output logic              mc_req,
    output logic [ADDR_W-1:0] mc_save_addr,
    output logic              mc_syndrome_ifetch
);
    localparam int OFF_W = $clog2(WORDS);

    logic              busy, start, beat_we, done;
    logic [OFF_W-1:0]  beat_word;
    logic [ADDR_W-1:0] line_addr;
    logic              fe_present, is_present, is_bad_tag, bad_issue;

    assign start     = fetch_req && fetch_cacheable && !fe_present && !busy;
    assign bad_issue = issue_valid && is_present && is_bad_tag;

    ifd_fill_ctrl #(.ADDR_W(ADDR_W), .WORDS(WORDS)) i_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (fetch_addr),
        .beat_valid (mem_beat_valid),
        .busy       (busy),
        .mem_req    (mem_req),
        .line_addr  (line_addr),
        .beat_we    (beat_we),
        .beat_word  (beat_word),
        .done       (done)
    );

    ifd_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES)) i_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_addr    (fetch_addr),
        .issue_addr    (issue_addr),
        .fill_begin    (start),
        .begin_addr    (fetch_addr),
        .fill_addr     (line_addr),
        .beat_we       (beat_we),
        .beat_word     (beat_word),
        .beat_data     (mem_beat_data),
        .beat_err      (mem_beat_err),
        .fill_done     (done),
        .inval_en      (bad_issue),
        .fetch_present (fe_present),
        .fetch_data    (fetch_data),
        .issue_present (is_present),
        .issue_bad_tag (is_bad_tag)
    );

    ifd_mc_capture #(.ADDR_W(ADDR_W)) i_mc (
        .clk       (clk),
        .rst_n     (rst_n),
        .bad_issue (bad_issue),
        .bad_addr  (issue_addr),
        .mc_req    (mc_req),
        .save_addr (mc_save_addr),
        .syndrome  (mc_syndrome_ifetch)
    );

    assign fetch_hit     = fetch_req && fe_present;
    assign mem_line_addr = line_addr;
    assign issue_kill    = bad_issue;

    // R3: no request unless an issue was killed the cycle before
    a_r3_silent_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_kill |=> !mc_req);
    // R6: every request is preceded by a kill
    a_r6_req_after_kill: assert property (@(posedge clk) disable iff (!rst_n)
        mc_req |-> $past(issue_kill));
    // R5: a kill only answers an actual issue attempt
    a_r5_kill_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
        issue_kill |-> issue_valid);
endmodule

// File: tb/test_ifd_unit.sv
`timescale 1ns/1ps
module test_ifd_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0, fetch_cacheable = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_hit;
    logic [31:0] fetch_data;
    logic        mem_req;
    logic [31:0] mem_line_addr;
    logic        mem_beat_valid = 1'b0, mem_beat_err = 1'b0;
    logic [31:0] mem_beat_data = '0;
    logic        issue_valid = 1'b0;
    logic [31:0] issue_addr = '0;
    logic        issue_kill, mc_req, mc_syndrome_ifetch;
    logic [31:0] mc_save_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [31:0] LA = 32'h0000_1000;
    localparam logic [31:0] LA2 = 32'h0000_3000;
    localparam logic [31:0] LB = 32'h0000_2020;
    localparam logic [31:0] LC = 32'h0000_4040;
    localparam logic [7:0]  LA_ERR = 8'b0010_0100;

    // {error flag, expected word} for each word of line LA
    localparam logic [32:0] VEC [8] = '{
        {1'b0, 32'h7000_1000}, {1'b0, 32'h7000_1004},
        {1'b1, 32'h7000_1008}, {1'b0, 32'h7000_100C},
        {1'b0, 32'h7000_1010}, {1'b1, 32'h7000_1014},
        {1'b0, 32'h7000_1018}, {1'b0, 32'h7000_101C}
    };

    always #2 clk = ~clk;

    ifd_unit i_ifd_unit (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_cacheable(fetch_cacheable),
        .fetch_hit(fetch_hit), .fetch_data(fetch_data),
        .mem_req(mem_req), .mem_line_addr(mem_line_addr),
        .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data), .mem_beat_err(mem_beat_err),
        .issue_valid(issue_valid), .issue_addr(issue_addr), .issue_kill(issue_kill),
        .mc_req(mc_req), .mc_save_addr(mc_save_addr), .mc_syndrome_ifetch(mc_syndrome_ifetch)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a, input int k);
        return {a[31:5], 5'b0} + 32'(k * 4) + 32'h7000_0000;
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic fill_line(input logic [31:0] a, input logic [7:0] errm,
                             input int hit_beat, input logic [31:0] iaddr);
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a; fetch_cacheable = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0; fetch_cacheable = 1'b0;
        #1;
        check("R1 mem_req", mem_req, 1);
        check("R1 line addr", mem_line_addr, {a[31:5], 5'b0});
        for (int k = 0; k < 8; k++) begin
            issue_valid    = 1'b0;
            mem_beat_valid = 1'b1;
            mem_beat_data  = word_of(a, k);
            mem_beat_err   = errm[k];
            if (k == hit_beat) begin
                issue_valid = 1'b1;
                issue_addr  = iaddr;
            end
            #1;
            if (k == 1) check("R1 mem_req single", mem_req, 0);
            if (k == hit_beat) check("R5 kill in fill", issue_kill, 1);
            else               check("R3 no kill", issue_kill, 0);
            if (hit_beat >= 0 && k == hit_beat + 1) begin
                check("R6 mc_req", mc_req, 1);
                check("R7 save addr", mc_save_addr, iaddr);
                check("R8 syndrome", mc_syndrome_ifetch, 1);
            end else begin
                check("R3 R6 no mc_req", mc_req, 0);
            end
            @(negedge clk);
        end
        mem_beat_valid = 1'b0;
        mem_beat_err   = 1'b0;
        issue_valid    = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, input logic exp_hit,
                         input logic [31:0] exp_data, input string rq);
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a; fetch_cacheable = 1'b0;
        #1;
        check(rq, fetch_hit, exp_hit);
        if (exp_hit) check(rq, fetch_data, exp_data);
        @(negedge clk);
        fetch_req = 1'b0;
    endtask

    task automatic issue_probe(input logic [31:0] a, input logic exp_kill, input string rq);
        @(negedge clk);
        issue_valid = 1'b1; issue_addr = a;
        #1;
        check(rq, issue_kill, exp_kill);
        @(negedge clk);
        issue_valid = 1'b0;
        #1;
        check(rq, mc_req, exp_kill);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R12 reset state
        check("R12 mem_req", mem_req, 0);
        check("R12 mc_req", mc_req, 0);
        check("R12 syndrome", mc_syndrome_ifetch, 0);
        check("R12 save addr", mc_save_addr, 0);
        @(negedge clk); rst_n = 1'b1;
        probe(LA, 1'b0, 0, "R12 no hit");

        // R2 non-cacheable miss allocates nothing
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            fetch_req = 1'b1; fetch_addr = LC; fetch_cacheable = 1'b0;
            #1;
            check("R2 no hit", fetch_hit, 0);
            check("R2 no mem_req", mem_req, 0);
        end
        @(negedge clk); fetch_req = 1'b0;
        #1; check("R2 no mem_req", mem_req, 0);

        // Table walk: line with bad words, every word fetched silently
        fill_line(LA, LA_ERR, -1, 0);
        for (int i = 0; i < 8; i++) begin
            check("R1 table err map", 32'(LA_ERR[i]), 32'(VEC[i][32]));
            probe(LA + 32'(i * 4), 1'b1, VEC[i][31:0], "R1 R3 fetch word");
            #1;
            check("R3 fetch stays silent", mc_req, 0);
        end

        // R4 clean words in a tainted line
        issue_probe(LA, 1'b0, "R4 clean word 0");
        issue_probe(LA + 32'hC, 1'b0, "R4 clean word 3");
        check("R4 syndrome clear", mc_syndrome_ifetch, 0);

        // R11 eviction before execution
        fill_line(LA2, 8'h00, -1, 0);
        probe(LA, 1'b0, 0, "R11 old line gone");
        issue_probe(LA + 32'h8, 1'b0, "R11 evicted bad word");
        check("R11 syndrome clear", mc_syndrome_ifetch, 0);

        // Machine check during a fill of another line (R5..R9)
        fill_line(LA, LA_ERR, -1, 0);
        fill_line(LB, 8'h00, 3, LA + 32'h14);
        probe(LA, 1'b0, 0, "R9 line invalid word 0");
        probe(LA + 32'h14, 1'b0, 0, "R9 line invalid word 5");
        probe(LB, 1'b1, word_of(LB, 0), "R1 other line word 0");
        probe(LB + 32'h1C, 1'b1, word_of(LB, 7), "R1 other line word 7");
        issue_probe(LA + 32'h14, 1'b0, "R9 no repeat after invalidate");

        // R10 clean refill clears the error
        fill_line(LA, 8'h00, -1, 0);
        issue_probe(LA + 32'h14, 1'b0, "R10 refilled word");
        issue_probe(LA + 32'h8, 1'b0, "R10 refilled word 2");
        check("R8 syndrome sticky", mc_syndrome_ifetch, 1);
        check("R7 save addr held", mc_save_addr, LA + 32'h14);

        // Second check directly from issue: R5 R6 R7
        fill_line(LA2, 8'b1000_0000, -1, 0);
        issue_probe(LA2 + 32'h1C, 1'b1, "R5 R6 second check");
        check("R7 save addr updated", mc_save_addr, LA2 + 32'h1C);
        @(negedge clk); #1;
        check("R6 single pulse", mc_req, 0);
        probe(LA2 + 32'h1C, 1'b0, 0, "R9 second line dropped");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule